// File: doc/BRIEF.md
# Queue Doorbell Pointer Manager

This block is the controller-side bookkeeping for one command ring and one completion ring that a host driver shares with a storage controller. The host programs the ring sizes and the two ring base addresses through a simple register port. It then moves its own ends of the rings by writing doorbell registers: the command tail after it queues new commands, and the completion head after it has consumed results.

The controller's datapath asks to fetch the next command over a request/acknowledge pair. An acknowledge comes only while commands are pending. The block presents the memory address of the entry and moves the command head forward. Another request/acknowledge pair posts completions. The block presents the address of the next completion slot, moves the completion tail forward and raises an interrupt. The interrupt holds until the host's completion head catches up.

Both rings wrap at their programmed size. A doorbell value that points outside its ring is dropped and latches an error flag.

Top module: `qdb_ptr_mgr`

## Requirements
- R1: After reset, the command tail, command head, completion head and completion tail all read as zero, and `irq` and `err` are low. A fetch request is not acknowledged.
- R2: Writing offset 0x24 sets the zero-based ring size fields: the command ring's last index in bits [PW-1:0] and the completion ring's last index in bits [16+PW-1:16]. Offset 0x28 holds the command ring base and offset 0x30 holds the completion ring base. All three read back as written.
- R3: A write to offset 0x40 sets the command tail, which reads back at 0x40. `fetch_ack` equals `fetch_req` while the tail differs from the head and is low otherwise. From tail 3 and head 0, exactly three fetches are acknowledged and the head then reads 3.
- R4: During an acknowledged fetch, `fetch_addr` equals the command base plus the head times 64. Each acknowledged fetch moves the head by one entry.
- R5: Each ring pointer returns to 0 after it leaves its last index.
- R6: During an acknowledged post, `post_addr` equals the completion base plus the completion tail times 16. Each acknowledged post moves the tail by one entry.
- R7: A post request is refused (`post_ack` low) when the tail plus one, modulo the ring size, equals the completion head.
- R8: `irq` goes high the clock after an acknowledged post. It stays high until the completion head doorbell (write at 0x44, read at 0x44) equals the completion tail, and falls one clock after that.
- R9: A doorbell write whose value exceeds that ring's size field leaves the pointer unchanged and sets `err`. `err` stays high until reset.
- R10: Offset 0x48 reads the controller-owned pointers: the command head in bits [PW-1:0] and the completion tail in bits [16+PW-1:16]. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 32 | Register read data (combinational) |
| fetch_req | input | 1 | Datapath asks for the next command |
| fetch_ack | output | 1 | Command available; head advances at this edge |
| fetch_addr | output | AW | Memory address of the command entry |
| post_req | input | 1 | Datapath asks to write a completion |
| post_ack | output | 1 | Slot available; tail advances at this edge |
| post_addr | output | AW | Memory address of the completion slot |
| irq | output | 1 | Completion interrupt to the host |
| err | output | 1 | Sticky out-of-range doorbell flag |

## Verification
The bench drains a command ring whose head starts in mid-ring and crosses the last index. A design with a faulty wrap would produce an address past the ring or give an extra acknowledge. It fills the completion ring until one slot stays free, which exposes a design that overwrites unread entries or refuses one entry too early. It clears the interrupt in two steps: with the head short of the tail, the interrupt must hold, and when the head matches, it must drop, so an early or sticky interrupt is caught. Out-of-range doorbells are read back to show that a design that accepts them would have corrupted the pointer.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
   localparam logic [7:0] OFS_ATTR = 8'h24;
   localparam logic [7:0] OFS_SQB  = 8'h28;
   localparam logic [7:0] OFS_CQB  = 8'h30;
   localparam logic [7:0] OFS_SQDB = 8'h40;
   localparam logic [7:0] OFS_CQDB = 8'h44;
   localparam logic [7:0] OFS_PTRS = 8'h48;
   localparam int         CQ_LSB   = 16;
   localparam int         DB_W     = 16;
   localparam int         REG_W    = 32;
   localparam int         CMD_SHIFT = 6;
   localparam int         CPL_SHIFT = 4;
   typedef enum int {Q_CMD = 0, Q_CPL = 1} q_kind_e;
endpackage

// File: rtl/qdb_ring.sv
module qdb_ring #(
   parameter int PW = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [PW-1:0]            last_i,
   input  logic                     db_we_i,
   input  logic [qdb_pkg::DB_W-1:0] db_val_i,
   input  logic                     adv_i,
   output logic [PW-1:0]            host_ptr_o,
   output logic [PW-1:0]            ctl_ptr_o,
   output logic [PW-1:0]            nxt_ptr_o,
   output logic                     bad_o
);
   localparam int DW = qdb_pkg::DB_W;

   if (PW < 1 || PW >= DW) begin : g_bad_pw
      $error("qdb_ring: PW must lie in 1..%0d", DW - 1);
   end

   logic [PW-1:0] host_q, ctl_q;
   logic          bad_q;
   logic          db_ok;

   assign db_ok     = db_val_i <= DW'(last_i);
   assign nxt_ptr_o = (ctl_q == last_i) ? '0 : ctl_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_q <= '0;
         ctl_q  <= '0;
         bad_q  <= 1'b0;
      end else begin
         if (db_we_i && db_ok)  host_q <= db_val_i[PW-1:0];
         if (db_we_i && !db_ok) bad_q  <= 1'b1;
         if (adv_i)             ctl_q  <= nxt_ptr_o;
      end
   end

   assign host_ptr_o = host_q;
   assign ctl_ptr_o  = ctl_q;
   assign bad_o      = bad_q;

   p_adv_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |=> ctl_q == (($past(ctl_q) == $past(last_i)) ? PW'(0) : PW'($past(ctl_q) + 1'b1)))
      else $error("ring pointer step wrong");

   p_db_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (db_we_i && (db_val_i > DW'(last_i))) |=> $stable(host_q))
      else $error("out-of-range doorbell accepted");

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bad_q |=> bad_q)
      else $error("error flag dropped");
endmodule

// File: rtl/qdb_addr.sv
module qdb_addr #(
   parameter int AW    = 32,
   parameter int PW    = 4,
   parameter int SHIFT = 6
) (
   input  logic [AW-1:0] base_i,
   input  logic [PW-1:0] idx_i,
   output logic [AW-1:0] addr_o
);
   if (PW + SHIFT > AW) begin : g_bad_w
      $error("qdb_addr: AW too narrow for PW+SHIFT");
   end

   assign addr_o = base_i + (AW'(idx_i) << SHIFT);
endmodule

// File: rtl/qdb_ptr_mgr.sv
module qdb_ptr_mgr #(
   parameter int AW = 32,
   parameter int PW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [7:0]    wr_addr,
   input  logic [31:0]   wr_data,
   input  logic [7:0]    rd_addr,
   output logic [31:0]   rd_data,
   input  logic          fetch_req,
   output logic          fetch_ack,
   output logic [AW-1:0] fetch_addr,
   input  logic          post_req,
   output logic          post_ack,
   output logic [AW-1:0] post_addr,
   output logic          irq,
   output logic          err
);
   import qdb_pkg::*;

   localparam int NQ = 2;

   if (AW < PW + CMD_SHIFT || AW > REG_W) begin : g_bad_aw
      $error("qdb_ptr_mgr: AW out of range");
   end
   if (PW + CQ_LSB > REG_W) begin : g_bad_pw
      $error("qdb_ptr_mgr: PW too wide for register layout");
   end

   logic [PW-1:0] last_a [NQ];
   logic [PW-1:0] host_a [NQ];
   logic [PW-1:0] ctl_a  [NQ];
   logic [PW-1:0] nxt_a  [NQ];
   logic [AW-1:0] base_a [NQ];
   logic [AW-1:0] addr_a [NQ];
   logic          we_a   [NQ];
   logic          adv_a  [NQ];
   logic          bad_a  [NQ];

   logic [AW-1:0] sqb_q, cqb_q;
   logic [PW-1:0] sq_last_q, cq_last_q;
   logic          irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sqb_q     <= '0;
         cqb_q     <= '0;
         sq_last_q <= '0;
         cq_last_q <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            OFS_ATTR: begin
               sq_last_q <= wr_data[PW-1:0];
               cq_last_q <= wr_data[CQ_LSB +: PW];
            end
            OFS_SQB: sqb_q <= AW'(wr_data);
            OFS_CQB: cqb_q <= AW'(wr_data);
            default: ;
         endcase
      end
   end

   assign last_a[Q_CMD] = sq_last_q;
   assign last_a[Q_CPL] = cq_last_q;
   assign base_a[Q_CMD] = sqb_q;
   assign base_a[Q_CPL] = cqb_q;
   assign we_a[Q_CMD]   = wr_en && (wr_addr == OFS_SQDB);
   assign we_a[Q_CPL]   = wr_en && (wr_addr == OFS_CQDB);

   for (genvar q = 0; q < NQ; q++) begin : g_q
      localparam int SH = (q == Q_CMD) ? CMD_SHIFT : CPL_SHIFT;
      qdb_ring #(.PW(PW)) u_ring (
         .clk        (clk),
         .rst_n      (rst_n),
         .last_i     (last_a[q]),
         .db_we_i    (we_a[q]),
         .db_val_i   (wr_data[DB_W-1:0]),
         .adv_i      (adv_a[q]),
         .host_ptr_o (host_a[q]),
         .ctl_ptr_o  (ctl_a[q]),
         .nxt_ptr_o  (nxt_a[q]),
         .bad_o      (bad_a[q])
      );
      qdb_addr #(.AW(AW), .PW(PW), .SHIFT(SH)) u_addr (
         .base_i (base_a[q]),
         .idx_i  (ctl_a[q]),
         .addr_o (addr_a[q])
      );
   end

   // command side: controller consumes while host tail is ahead of head
   assign fetch_ack    = fetch_req && (host_a[Q_CMD] != ctl_a[Q_CMD]);
   assign adv_a[Q_CMD] = fetch_ack;
   assign fetch_addr   = addr_a[Q_CMD];

   // completion side: one slot kept free to tell full from empty
   assign post_ack     = post_req && (nxt_a[Q_CPL] != host_a[Q_CPL]);
   assign adv_a[Q_CPL] = post_ack;
   assign post_addr    = addr_a[Q_CPL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          irq_q <= 1'b0;
      else if (post_ack)                                   irq_q <= 1'b1;
      else if (irq_q && host_a[Q_CPL] == ctl_a[Q_CPL])     irq_q <= 1'b0;
   end

   assign irq = irq_q;
   assign err = bad_a[Q_CMD] || bad_a[Q_CPL];

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         OFS_ATTR: begin
            rd_data[PW-1:0]      = sq_last_q;
            rd_data[CQ_LSB +: PW] = cq_last_q;
         end
         OFS_SQB:  rd_data = REG_W'(sqb_q);
         OFS_CQB:  rd_data = REG_W'(cqb_q);
         OFS_SQDB: rd_data[PW-1:0] = host_a[Q_CMD];
         OFS_CQDB: rd_data[PW-1:0] = host_a[Q_CPL];
         OFS_PTRS: begin
            rd_data[PW-1:0]      = ctl_a[Q_CMD];
            rd_data[CQ_LSB +: PW] = ctl_a[Q_CPL];
         end
         default: ;
      endcase
   end

   p_irq_after_post_r8: assert property (@(posedge clk) disable iff (!rst_n)
      post_ack |=> irq)
      else $error("no interrupt after post");

   p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && (host_a[Q_CPL] != ctl_a[Q_CPL])) |=> irq)
      else $error("interrupt dropped with entries unread");

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      post_ack |=> (ctl_a[Q_CPL] != host_a[Q_CPL]))
      else $error("completion ring overran host head");

   p_fetch_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_ack && !we_a[Q_CMD]) |=> $stable(host_a[Q_CMD]))
      else $error("fetch disturbed host tail");
endmodule

// File: tb/sim_qdb_ptr_mgr.sv
`timescale 1ns/1ps
module sim_qdb_ptr_mgr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        fetch_req = 1'b0, fetch_ack;
   logic [31:0] fetch_addr;
   logic        post_req = 1'b0, post_ack;
   logic [31:0] post_addr;
   logic        irq, err;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   qdb_ptr_mgr #(.AW(32), .PW(4)) u0 (.*);

   // {op, arg, exp}; op 0=write(arg=addr<<?..) see walk; NOACK marks a refused handshake
   localparam logic [31:0] NOACK = 32'hFFFF_FFFF;
   localparam int NV = 15;
   localparam logic [73:0] VEC [NV] = '{
      {2'd0, 8'h24, 32'h0003_0007, 32'h0},   // R2 sizes: cmd 8, cpl 4
      {2'd0, 8'h28, 32'h0000_1000, 32'h0},   // R2 cmd base
      {2'd0, 8'h30, 32'h0000_2000, 32'h0},   // R2 cpl base
      {2'd3, 8'h24, 32'h0,         32'h0003_0007},
      {2'd0, 8'h40, 32'h3,         32'h0},   // R3 tail = 3
      {2'd1, 8'h00, 32'h0,         32'h0000_1000},
      {2'd1, 8'h00, 32'h0,         32'h0000_1040},
      {2'd1, 8'h00, 32'h0,         32'h0000_1080},
      {2'd1, 8'h00, 32'h0,         NOACK},
      {2'd3, 8'h48, 32'h0,         32'h0000_0003},
      {2'd2, 8'h00, 32'h0,         32'h0000_2000},
      {2'd2, 8'h00, 32'h0,         32'h0000_2010},
      {2'd2, 8'h00, 32'h0,         32'h0000_2020},
      {2'd2, 8'h00, 32'h0,         NOACK},   // R7 ring full
      {2'd3, 8'h48, 32'h0,         32'h0003_0003}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic fetch(input logic [31:0] exp);
      @(negedge clk);
      fetch_req = 1'b1;
      #1;
      if (exp === NOACK) chk("R3 fetch refused", {31'd0, fetch_ack}, 32'd0);
      else begin
         chk("R3 fetch ack", {31'd0, fetch_ack}, 32'd1);
         chk("R4 fetch addr", fetch_addr, exp);
      end
      @(negedge clk);
      fetch_req = 1'b0;
   endtask

   task automatic post(input logic [31:0] exp);
      @(negedge clk);
      post_req = 1'b1;
      #1;
      if (exp === NOACK) chk("R7 post refused", {31'd0, post_ack}, 32'd0);
      else begin
         chk("R6 post ack", {31'd0, post_ack}, 32'd1);
         chk("R6 post addr", post_addr, exp);
      end
      @(negedge clk);
      post_req = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd("R1 cmd tail", 8'h40, 32'h0);
      rd("R1 cpl head", 8'h44, 32'h0);
      rd("R1 ctl ptrs", 8'h48, 32'h0);
      chk("R1 irq", {31'd0, irq}, 32'd0);
      chk("R1 err", {31'd0, err}, 32'd0);
      fetch_req = 1'b1; #1;
      chk("R1 no fetch", {31'd0, fetch_ack}, 32'd0);
      fetch_req = 1'b0;

      for (int i = 0; i < NV; i++) begin
         logic [1:0]  op;
         logic [7:0]  a;
         logic [31:0] d, e;
         {op, a, d, e} = VEC[i];
         case (op)
            2'd0: wr(a, d);
            2'd1: fetch(e);
            2'd2: post(e);
            default: begin @(negedge clk); rd("R2 R10 readback", a, e); end
         endcase
      end

      rd("R2 cmd base", 8'h28, 32'h0000_1000);
      rd("R2 cpl base", 8'h30, 32'h0000_2000);
      rd("R3 tail readback", 8'h40, 32'h3);
      rd("R10 unmapped", 8'h50, 32'h0);

      // R8: interrupt holds until head meets tail (tail is 3)
      chk("R8 irq up", {31'd0, irq}, 32'd1);
      wr(8'h44, 32'h2);
      @(negedge clk);
      chk("R8 irq held", {31'd0, irq}, 32'd1);
      wr(8'h44, 32'h3);
      rd("R8 head readback", 8'h44, 32'h3);
      @(negedge clk);
      chk("R8 irq cleared", {31'd0, irq}, 32'd0);

      // R5: command head 3 runs to 7, wraps to 0, stops at tail 1
      wr(8'h40, 32'h1);
      fetch(32'h0000_10C0);
      fetch(32'h0000_1100);
      fetch(32'h0000_1140);
      fetch(32'h0000_1180);
      fetch(32'h0000_11C0);
      fetch(32'h0000_1000);   // R5 wrapped
      fetch(NOACK);
      rd("R5 head after wrap", 8'h48, 32'h0003_0001);

      // R5/R6: completion tail 3 wraps to 0
      post(32'h0000_2030);
      post(32'h0000_2000);
      rd("R5 cpl tail wrap", 8'h48, 32'h0001_0001);
      chk("R8 irq again", {31'd0, irq}, 32'd1);

      // R9 out-of-range doorbells
      wr(8'h40, 32'h8);
      rd("R9 cmd tail kept", 8'h40, 32'h1);
      chk("R9 err set", {31'd0, err}, 32'd1);
      wr(8'h44, 32'h4);
      rd("R9 cpl head kept", 8'h44, 32'h3);
      repeat (3) @(negedge clk);
      chk("R9 err sticky", {31'd0, err}, 32'd1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule